// File: doc/BRIEF.md
# Sensor Health Alarm Monitor

This block watches a stream of converted samples. Each sample carries a channel number. Channel 0 is the die temperature and channels 1 to NCH-1 are supply rails. For every channel it keeps the largest and smallest value seen since reset. It also keeps a hysteretic alarm: the alarm turns on when a sample leaves the allowed band and turns off only after a sample comes back inside a narrower band.

A small word-wide register port lets software set the thresholds and read the extremes and the status. The block drives one alarm line per channel, an OR of all of them, a sticky interrupt and an over-temperature shutdown request. The shutdown request is armed by a code in the temperature trigger register. It fires a fixed number of clock cycles after the temperature alarm starts. Once it is up, it holds until the temperature has cooled below its release level.

Top module: `shm_top`

## Requirements
- R1: After reset every channel's maximum reads 0 and its minimum reads all ones. Each accepted sample for channel c raises that channel's maximum and lowers its minimum when the sample is beyond them. Other channels are left unchanged.
- R2: A channel's alarm sets on a sample strictly above its upper trigger. It clears only on a sample strictly below its upper release level that is also inside the lower band (R3). Samples between the two levels leave the alarm unchanged. The alarm line changes on the clock edge that takes the sample.
- R3: On voltage channels (1 and up), a sample strictly below the lower trigger also sets the alarm. Clearing also requires the sample to be strictly above the lower release level.
- R4: The temperature channel (0) stores its lower thresholds for readback but never uses them, neither to set its alarm nor to clear it.
- R5: `alarm_any_o` is the OR of all channel alarms. The status word (slot NCH, field 0) holds the alarms in bits NCH-1:0, the OR in bit NCH, shutdown in bit NCH+1 and the interrupt in bit NCH+2.
- R6: The interrupt is set the cycle after any channel alarm rises and stays set. A write to the status address with bit NCH+2 set clears it.
- R7: Auto-shutdown is armed only when bits 3:0 of channel 0's upper trigger are all ones. When armed, `shutdown_o` rises exactly DELAY_CYC cycles after `alarm_o[0]` rises, provided the alarm stays on.
- R8: If the temperature alarm clears before the delay runs out, the pending shutdown is dropped. A later alarm starts a full new delay.
- R9: Once `shutdown_o` is up, it stays up while `alarm_o[0]` is on and falls one cycle after that alarm clears. While it is up, threshold writes are ignored.
- R10: Channels whose PRESENT bit is 0 never raise their alarm, and all of their register fields read 0.
- R11: Register address = channel*8 + field. The fields are: 0 upper trigger, 1 upper release, 2 lower trigger, 3 lower release, 4 maximum, 5 minimum. Read data appears the cycle after the address. Reset values are all ones for the upper fields and 0 for the lower fields.
- R12: Samples tagged with a channel number of NCH or above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CHW | Channel tag of the sample |
| smp_data | input | DW | Sample code, unsigned |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | CHW+3 | Register address (channel slot, field) |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Registered read data |
| alarm_o | output | NCH | Per-channel alarm lines |
| alarm_any_o | output | 1 | OR of all alarms |
| irq_o | output | 1 | Sticky interrupt request |
| shutdown_o | output | 1 | Over-temperature shutdown request |

## Verification
The bench drives samples that sit exactly on a trigger level, one code past it, and between the trigger and release levels. A design with the wrong compare sense, or without hysteresis, shows a wrong alarm at one of these points. It times the shutdown delay to the exact cycle with the arming code both present and absent. It also lets the alarm drop halfway through the delay, which catches a counter that is not restarted. It writes thresholds while shutdown is up, hits the absent channel and an out-of-range tag, and sets the temperature channel's lower trigger high. Any leak of writes, tags or lower-band logic then shows up as a wrong readback or a stray alarm.

// File: rtl/shm_pkg.sv
package shm_pkg;
  // Field selector inside one channel's 8-word register slot
  typedef enum logic [2:0] {
    FLD_UTRIG = 3'd0,
    FLD_URST  = 3'd1,
    FLD_LTRIG = 3'd2,
    FLD_LRST  = 3'd3,
    FLD_MAX   = 3'd4,
    FLD_MIN   = 3'd5
  } fld_e;
endpackage

// File: rtl/shm_chan.sv
module shm_chan
  import shm_pkg::*;
#(
  parameter int DW      = 12,
  parameter bit HAS_LOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  fld_e          wr_fld,
  input  logic [DW-1:0] wr_data,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  output logic          alarm_o,
  output logic [DW-1:0] max_o,
  output logic [DW-1:0] min_o,
  output logic [DW-1:0] utrig_o,
  output logic [DW-1:0] urst_o,
  output logic [DW-1:0] ltrig_o,
  output logic [DW-1:0] lrst_o
);
  logic trip, calm;

  // trip: sample outside the trigger band; calm: sample back inside release band
  always_comb begin
    trip = (smp_data > utrig_o) || (HAS_LOW && (smp_data < ltrig_o));
    calm = (smp_data < urst_o) && (!HAS_LOW || (smp_data > lrst_o));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      utrig_o <= '1;
      urst_o  <= '1;
      ltrig_o <= '0;
      lrst_o  <= '0;
      max_o   <= '0;
      min_o   <= '1;
      alarm_o <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_fld)
          FLD_UTRIG: utrig_o <= wr_data;
          FLD_URST:  urst_o  <= wr_data;
          FLD_LTRIG: ltrig_o <= wr_data;
          FLD_LRST:  lrst_o  <= wr_data;
          default:   ;
        endcase
      end
      if (smp_vld) begin
        if (smp_data > max_o) max_o <= smp_data;
        if (smp_data < min_o) min_o <= smp_data;
        if (trip)      alarm_o <= 1'b1;
        else if (calm) alarm_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shm_otshut.sv
module shm_otshut #(
  parameter int DELAY_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic alarm_i,
  output logic shdn_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      shdn_o <= 1'b0;
    end else if (shdn_o) begin
      cnt <= '0;
      if (!alarm_i) shdn_o <= 1'b0;
    end else if (alarm_i && arm_i) begin
      if (cnt == LAST) begin
        shdn_o <= 1'b1;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/shm_top.sv
module shm_top
  import shm_pkg::*;
#(
  parameter int           DW        = 12,
  parameter int           NCH       = 7,
  parameter logic [NCH-1:0] PRESENT = '1,
  parameter int           DELAY_CYC = 500000,
  localparam int          CHW       = $clog2(NCH + 1),
  localparam int          AW        = CHW + 3,
  localparam int          RW        = (DW > NCH + 3) ? DW : NCH + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic [CHW-1:0] smp_chan,
  input  logic [DW-1:0]  smp_data,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  output logic [NCH-1:0] alarm_o,
  output logic           alarm_any_o,
  output logic           irq_o,
  output logic           shutdown_o
);
  localparam logic [CHW-1:0] STAT_SLOT = CHW'(NCH);

  logic [CHW-1:0]          slot;
  fld_e                    fld;
  logic [NCH-1:0]          alarm_w, alarm_prev;
  logic [NCH-1:0][DW-1:0]  utrig_w, urst_w, ltrig_w, lrst_w, max_w, min_w;
  logic [RW-1:0]           rd_nx;
  logic                    irq_set, irq_clr;

  assign slot = reg_addr[AW-1:3];
  assign fld  = fld_e'(reg_addr[2:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (PRESENT[c]) begin : g_on
      shm_chan #(.DW(DW), .HAS_LOW(c != 0)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr && !shutdown_o && (slot == CHW'(c))),
        .wr_fld  (fld),
        .wr_data (reg_wdata[DW-1:0]),
        .smp_vld (smp_valid && (smp_chan == CHW'(c))),
        .smp_data(smp_data),
        .alarm_o (alarm_w[c]),
        .max_o   (max_w[c]),
        .min_o   (min_w[c]),
        .utrig_o (utrig_w[c]),
        .urst_o  (urst_w[c]),
        .ltrig_o (ltrig_w[c]),
        .lrst_o  (lrst_w[c])
      );
    end else begin : g_off
      assign alarm_w[c] = 1'b0;
      assign max_w[c]   = '0;
      assign min_w[c]   = '0;
      assign utrig_w[c] = '0;
      assign urst_w[c]  = '0;
      assign ltrig_w[c] = '0;
      assign lrst_w[c]  = '0;
    end
  end

  // Over-temperature shutdown: armed by all-ones low nibble of channel 0 trigger
  shm_otshut #(.DELAY_CYC(DELAY_CYC)) u_ot (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (&utrig_w[0][3:0]),
    .alarm_i(alarm_w[0]),
    .shdn_o (shutdown_o)
  );

  assign alarm_o     = alarm_w;
  assign alarm_any_o = |alarm_w;
  assign irq_set     = |(alarm_w & ~alarm_prev);
  assign irq_clr     = reg_wr && (slot == STAT_SLOT) && (reg_addr[2:0] == 3'd0)
                       && reg_wdata[NCH+2];

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_prev <= '0;
      irq_o      <= 1'b0;
    end else begin
      alarm_prev <= alarm_w;
      irq_o      <= irq_set | (irq_o & ~irq_clr);
    end
  end

  always_comb begin
    rd_nx = '0;
    if (slot == STAT_SLOT && reg_addr[2:0] == 3'd0) begin
      rd_nx[NCH-1:0] = alarm_w;
      rd_nx[NCH]     = |alarm_w;
      rd_nx[NCH+1]   = shutdown_o;
      rd_nx[NCH+2]   = irq_o;
    end
    for (int c = 0; c < NCH; c++) begin
      if (slot == c[CHW-1:0]) begin
        case (fld)
          FLD_UTRIG: rd_nx[DW-1:0] = utrig_w[c];
          FLD_URST:  rd_nx[DW-1:0] = urst_w[c];
          FLD_LTRIG: rd_nx[DW-1:0] = ltrig_w[c];
          FLD_LRST:  rd_nx[DW-1:0] = lrst_w[c];
          FLD_MAX:   rd_nx[DW-1:0] = max_w[c];
          FLD_MIN:   rd_nx[DW-1:0] = min_w[c];
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nx;
  end
endmodule

// File: rtl/shm_chk.sv
module shm_chk #(
  parameter int             NCH     = 7,
  parameter logic [NCH-1:0] PRESENT = '1,
  parameter int             AW      = 6,
  parameter int             RW      = 12
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] alarm_o,
  input logic           irq_o,
  input logic           shutdown_o,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [RW-1:0]  reg_wdata
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NCH * 8);

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (alarm_o & ~PRESENT) == '0); // R10

  AST_IRQ_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(reg_wr && reg_addr == STAT_ADDR && reg_wdata[NCH+2])); // R6

  AST_SHDN_NEEDS_TEMP: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown_o) |-> $past(alarm_o[0])); // R7

  AST_SHDN_LATCH: assert property (@(posedge clk) disable iff (rst)
    (shutdown_o && alarm_o[0]) |=> shutdown_o); // R9

  AST_SHDN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (shutdown_o && !alarm_o[0]) |=> !shutdown_o); // R9
endmodule

bind shm_top shm_chk #(.NCH(NCH), .PRESENT(PRESENT), .AW(AW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .alarm_o   (alarm_o),
  .irq_o     (irq_o),
  .shutdown_o(shutdown_o),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/sim_shm_top.sv
module sim_shm_top;
  localparam int DW  = 12;
  localparam int NCH = 7;
  localparam int DLY = 16;
  localparam logic [NCH-1:0] PRES = 7'b0111111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [2:0]  smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic [6:0]  alarm_o;
  logic        alarm_any_o, irq_o, shutdown_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] exp;
    int          issued;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  shm_top #(.DW(DW), .NCH(NCH), .PRESENT(PRES), .DELAY_CYC(DLY)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_o(alarm_o),
    .alarm_any_o(alarm_any_o), .irq_o(irq_o), .shutdown_o(shutdown_o)
  );

  function automatic logic [5:0] ad(int ch, int f);
    return 6'(ch * 8 + f);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: present address, queue expectation
  task automatic rd(logic [5:0] a, logic [11:0] exp, string tag);
    rd_item_t it;
    @(negedge clk);
    reg_addr = a;
    it.exp = exp; it.issued = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor side: pop each item once its registered data is out
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].issued < cyc) begin
      rd_item_t it;
      it = sb.pop_front();
      chk(it.tag, {20'd0, reg_rdata}, {20'd0, it.exp});
    end
  end

  task automatic wr(logic [5:0] a, logic [11:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic smp(int ch, logic [11:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = 3'(ch); smp_data = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R11 reset alarms", alarm_o, 0);
    chk("R11 reset any", alarm_any_o, 0);
    chk("R6 reset irq", irq_o, 0);
    chk("R7 reset shdn", shutdown_o, 0);
    rd(ad(1, 4), 12'h000, "R1 reset max");
    rd(ad(1, 5), 12'hFFF, "R1 reset min");
    rd(ad(0, 0), 12'hFFF, "R11 reset utrig");
    rd(ad(3, 3), 12'h000, "R11 reset lrst");

    // min / max tracking
    smp(1, 12'h400); smp(1, 12'h300); smp(1, 12'h500);
    rd(ad(1, 4), 12'h500, "R1 max");
    rd(ad(1, 5), 12'h300, "R1 min");
    rd(ad(2, 4), 12'h000, "R1 other chan max");

    // out-of-range tag
    smp(7, 12'h7FF);
    chk("R12 no alarm", alarm_o, 0);
    rd(ad(1, 4), 12'h500, "R12 ch1 max");
    rd(ad(0, 4), 12'h000, "R12 ch0 max");

    // hysteresis on ch1
    wr(ad(1, 0), 12'h800); wr(ad(1, 1), 12'h700);
    wr(ad(1, 2), 12'h100); wr(ad(1, 3), 12'h200);
    smp(1, 12'h800);
    chk("R2 on trigger no alarm", alarm_o[1], 0);
    smp(1, 12'h801);
    chk("R2 above trigger", alarm_o[1], 1);
    chk("R5 any", alarm_any_o, 1);
    @(negedge clk);
    chk("R6 irq set", irq_o, 1);
    smp(1, 12'h750);
    chk("R2 hold", alarm_o[1], 1);
    smp(1, 12'h6FF);
    chk("R2 release", alarm_o[1], 0);
    smp(1, 12'h0FF);
    chk("R3 lower trip", alarm_o[1], 1);
    smp(1, 12'h150);
    chk("R3 lower hold", alarm_o[1], 1);
    smp(1, 12'h201);
    chk("R3 lower release", alarm_o[1], 0);

    // status and irq clear
    rd(ad(7, 0), 12'h200, "R5 status irq only");
    wr(ad(7, 0), 12'h200);
    chk("R6 irq cleared", irq_o, 0);
    wr(ad(2, 0), 12'h900);
    smp(2, 12'hA00);
    rd(ad(7, 0), 12'h284, "R5 status ch2");
    smp(2, 12'h100);
    chk("R5 any cleared", alarm_any_o, 0);
    wr(ad(7, 0), 12'h200);

    // temperature ignores lower band
    wr(ad(0, 2), 12'h800);
    smp(0, 12'h400);
    chk("R4 temp no low trip", alarm_o[0], 0);
    rd(ad(0, 2), 12'h800, "R4 ltrig stored");

    // absent channel 6
    wr(ad(6, 0), 12'h010);
    smp(6, 12'h500);
    chk("R10 absent alarm", alarm_o[6], 0);
    rd(ad(6, 0), 12'h000, "R10 absent utrig");
    rd(ad(6, 4), 12'h000, "R10 absent max");

    // shutdown not armed
    wr(ad(0, 0), 12'h600); wr(ad(0, 1), 12'h500);
    smp(0, 12'h700);
    chk("R7 temp alarm", alarm_o[0], 1);
    repeat (DLY + 4) @(negedge clk);
    chk("R7 unarmed no shdn", shutdown_o, 0);
    smp(0, 12'h400);
    chk("R4 temp release", alarm_o[0], 0);

    // armed: exact delay
    wr(ad(0, 0), 12'h60F);
    smp(0, 12'h700);
    repeat (DLY - 1) @(negedge clk);
    chk("R7 before delay", shutdown_o, 0);
    @(negedge clk);
    chk("R7 at delay", shutdown_o, 1);
    wr(ad(0, 0), 12'h7FF);
    rd(ad(0, 0), 12'h60F, "R9 write blocked");
    smp(0, 12'h550);
    chk("R9 latched", shutdown_o, 1);
    smp(0, 12'h4FF);
    chk("R9 alarm off", alarm_o[0], 0);
    @(negedge clk);
    chk("R9 released", shutdown_o, 0);

    // cancel then restart
    smp(0, 12'h700);
    repeat (8) @(negedge clk);
    smp(0, 12'h400);
    repeat (DLY + 4) @(negedge clk);
    chk("R8 cancelled", shutdown_o, 0);
    smp(0, 12'h700);
    repeat (DLY - 1) @(negedge clk);
    chk("R8 full restart early", shutdown_o, 0);
    @(negedge clk);
    chk("R8 full restart fire", shutdown_o, 1);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule